// File: doc/BRIEF.md
# CGMS Line Data Inserter

This block places a 14-bit copy-generation management word on one chosen line of every frame of a progressive standard-definition video stream. On every other line it passes the incoming video samples through unchanged. A host writes the word through a small register port. The six header bits go to one register and the eight payload bits go to another. A control register holds the enable bit.

Field writes only fill shadow registers. The word that is transmitted changes only when the host writes the control register. A control write with the enable bit set takes a snapshot of both shadow fields, so a half-written word never reaches the video. A control write with the enable bit clear turns insertion off. If a committed change lands while the insertion line is being sent, the change waits until that line has ended, so it first appears in the next frame.

The block counts lines from the frame-start pulse, using the line-start pulses. On the insertion line it replaces the video with two levels. The first bit starts a fixed number of clocks after the line begins, and the bits are sent most significant first. In the double-rate interpolation mode, both the start offset and the bit length are doubled, so the timing within the line stays the same.

Top module: `cgms_inserter`

## Requirements
- R1: After reset, insertion is disabled, `ins_active_o` is 0 and `video_o` equals `video_i`.
- R2: A `vsync_i` pulse makes the following line number 1, and each `hsync_i` pulse adds one. Insertion happens only on line `INS_LINE` (default 41). The pulse cycle itself still belongs to the line that is ending.
- R3: The sent word is {header[5:0], payload[7:0]}. The header comes from bits 5:0 of address 0 and the payload from bits 7:0 of address 1. The word is sent from bit 13 down to bit 0. A 1 bit drives `LVL_HI` and a 0 bit drives `LVL_LO`.
- R4: In single-rate mode, let clock 0 be the first cycle after the line-start pulse. Bit k occupies clocks `START_OFS + k*BIT_CLKS` up to `START_OFS + (k+1)*BIT_CLKS - 1`. All other cycles of an active insertion line output `LVL_LO`.
- R5: When `mode_2x_i` is 1, both the start offset and the bit length are doubled.
- R6: Writes to address 0 or address 1 alone do not change the word that is sent.
- R7: A write to address 2 with bit 0 = 1 commits the shadow fields and enables insertion. A write to address 2 with bit 0 = 0 disables insertion, and the insertion line then passes video through.
- R8: A commit made during the insertion line does not alter that line. It takes effect on the insertion line of the next frame.
- R9: Lines other than the insertion line pass `video_i` to `video_o` in the same cycle. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Host register write strobe |
| wr_addr_i | input | 2 | Register address: 0 header, 1 payload, 2 control |
| wr_data_i | input | 8 | Register write data |
| mode_2x_i | input | 1 | Double-rate interpolation mode |
| vsync_i | input | 1 | Frame-start pulse, one cycle |
| hsync_i | input | 1 | Line-start pulse, one cycle |
| video_i | input | DATA_W | Incoming video sample |
| video_o | output | DATA_W | Outgoing video sample |
| ins_active_o | output | 1 | High while the insertion line carries the word |

## Verification
Two functions can fall in the same cycle: a host commit, and the serialization of the insertion line that uses the working word. The bench provokes this with a control write at clock 30 of line 41, while bits are being sent. It then checks every sample of that line against the old word. On the next frame it checks every sample of line 41 against the newly committed word.

// File: rtl/cgms_pkg.sv
// Shared types for the line data inserter.
// Assumes: a 6-bit header and an 8-bit payload form the 14-bit word.
package cgms_pkg;
    localparam int HDR_W  = 6;
    localparam int PAY_W  = 8;
    localparam int WORD_W = HDR_W + PAY_W;

    typedef enum logic [1:0] {
        REG_HDR = 2'd0,
        REG_PAY = 2'd1,
        REG_CTL = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic [HDR_W-1:0] hdr;
        logic [PAY_W-1:0] pay;
        logic             en;
    } cgms_cfg_t;
endpackage

// File: rtl/cgms_line_ctr.sv
// Line counter: a frame pulse makes the next line number 1, and each
// line pulse adds one. Flags the insertion line.
// Assumes: vsync and hsync are single-cycle pulses; vsync wins a tie.
module cgms_line_ctr #(
    parameter int LINE_W   = 10,
    parameter int INS_LINE = 41
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_i,
    input  logic hsync_i,
    output logic line_start_o,
    output logic ins_line_o
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};
    localparam logic [LINE_W-1:0] LINE_INS = LINE_W'(INS_LINE);

    logic [LINE_W-1:0] cnt_q;

    // Track the current line number; saturate on very long frames
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (vsync_i)
            cnt_q <= LINE_W'(1);
        else if (hsync_i && cnt_q != LINE_MAX)
            cnt_q <= cnt_q + LINE_W'(1);
    end

    assign line_start_o = vsync_i | hsync_i;
    assign ins_line_o   = (cnt_q == LINE_INS);

    AST_VSYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_i |=> cnt_q == LINE_W'(1)); // R2
    AST_HSYNC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_i && !vsync_i && cnt_q != LINE_MAX) |=> cnt_q == $past(cnt_q) + LINE_W'(1)); // R2
endmodule

// File: rtl/cgms_regs.sv
// Host registers: shadow fields, a staged snapshot taken at a control
// write, and the working copy used by the serializer.
// Assumes: one write per cycle; the working copy must not change while
// the insertion line is being sent.
module cgms_regs
    import cgms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [1:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic       line_start_i,
    input  logic       ins_line_i,
    output cgms_cfg_t  work_o
);
    logic [HDR_W-1:0] shd_hdr_q;
    logic [PAY_W-1:0] shd_pay_q;
    cgms_cfg_t        stage_q;
    cgms_cfg_t        work_q;
    logic             pend_q;
    logic             apply;
    logic             ctl_wr;
    logic             unused_hi;

    assign unused_hi = ^wr_data_i[7:HDR_W];
    assign ctl_wr    = wr_en_i && (wr_addr_i == REG_CTL);
    assign apply     = pend_q && (!ins_line_i || line_start_i);

    // Capture field writes in the shadow registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_hdr_q <= '0;
            shd_pay_q <= '0;
        end else if (wr_en_i && wr_addr_i == REG_HDR) begin
            shd_hdr_q <= wr_data_i[HDR_W-1:0];
        end else if (wr_en_i && wr_addr_i == REG_PAY) begin
            shd_pay_q <= wr_data_i[PAY_W-1:0];
        end
    end

    // Snapshot the shadow fields on a control write and mark it pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            pend_q  <= 1'b0;
        end else if (ctl_wr) begin
            stage_q <= '{hdr: shd_hdr_q, pay: shd_pay_q, en: wr_data_i[0]};
            pend_q  <= 1'b1;
        end else if (apply) begin
            pend_q  <= 1'b0;
        end
    end

    // Move the pending snapshot to the working copy outside the insertion line
    always_ff @(posedge clk) begin
        if (!rst_n)
            work_q <= '0;
        else if (apply)
            work_q <= stage_q;
    end

    assign work_o = work_q;

    AST_MIDLINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_line_i && !line_start_i) |=> $stable(work_q)); // R8
    AST_FIELD_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != REG_CTL && !pend_q) |=> $stable(work_q)); // R6
endmodule

// File: rtl/cgms_bit_timer.sv
// Bit timer: waits a start offset after each line start, then steps
// through the word from the top bit down, one bit per bit period.
// Assumes: START_OFS and BIT_CLKS are at least 1; mode is steady within a line.
module cgms_bit_timer
    import cgms_pkg::*;
#(
    parameter int BIT_CLKS  = 4,
    parameter int START_OFS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start_i,
    input  logic              mode_2x_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              bit_o
);
    localparam int MAXV  = 2 * ((START_OFS > BIT_CLKS) ? START_OFS : BIT_CLKS);
    localparam int CW    = $clog2(MAXV + 1);
    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

    typedef enum logic [1:0] {T_WAIT, T_SEND, T_DONE} tstate_e;

    tstate_e          state_q;
    logic [CW-1:0]    cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [CW-1:0]    ofs_eff;
    logic [CW-1:0]    bc_eff;

    assign ofs_eff = mode_2x_i ? CW'(2 * START_OFS) : CW'(START_OFS);
    assign bc_eff  = mode_2x_i ? CW'(2 * BIT_CLKS)  : CW'(BIT_CLKS);

    // Sequence the offset wait, the bit periods and the idle tail of a line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T_DONE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else if (line_start_i) begin
            state_q <= T_WAIT;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                T_WAIT: begin
                    if (cnt_q == ofs_eff - CW'(1)) begin
                        state_q <= T_SEND;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                T_SEND: begin
                    if (cnt_q == bc_eff - CW'(1)) begin
                        cnt_q <= '0;
                        if (idx_q == LAST)
                            state_q <= T_DONE;
                        else
                            idx_q <= idx_q + IDX_W'(1);
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: state_q <= T_DONE;
            endcase
        end
    end

    assign bit_o = (state_q == T_SEND) && word_i[LAST - idx_q];

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_SEND && !line_start_i && cnt_q != bc_eff - CW'(1)) |=> $stable(idx_q)); // R4
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_SEND) |-> idx_q <= LAST); // R3
endmodule

// File: rtl/cgms_inserter.sv
// Top level: ties the line counter, the host registers and the bit timer
// together, and switches the video output to the data levels on the
// insertion line while insertion is enabled.
// Assumes: video_i is valid every cycle; the output is combinational.
module cgms_inserter
    import cgms_pkg::*;
#(
    parameter int               DATA_W    = 10,
    parameter int               LINE_W    = 10,
    parameter int               INS_LINE  = 41,
    parameter int               BIT_CLKS  = 4,
    parameter int               START_OFS = 8,
    parameter logic [DATA_W-1:0] LVL_LO   = DATA_W'(64),
    parameter logic [DATA_W-1:0] LVL_HI   = DATA_W'(700)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              mode_2x_i,
    input  logic              vsync_i,
    input  logic              hsync_i,
    input  logic [DATA_W-1:0] video_i,
    output logic [DATA_W-1:0] video_o,
    output logic              ins_active_o
);
    logic      line_start;
    logic      ins_line;
    cgms_cfg_t work;
    logic      tx_bit;

    cgms_line_ctr #(.LINE_W(LINE_W), .INS_LINE(INS_LINE)) i_line_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .vsync_i      (vsync_i),
        .hsync_i      (hsync_i),
        .line_start_o (line_start),
        .ins_line_o   (ins_line)
    );

    cgms_regs i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .line_start_i (line_start),
        .ins_line_i   (ins_line),
        .work_o       (work)
    );

    cgms_bit_timer #(.BIT_CLKS(BIT_CLKS), .START_OFS(START_OFS)) i_bit_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start),
        .mode_2x_i    (mode_2x_i),
        .word_i       ({work.hdr, work.pay}),
        .bit_o        (tx_bit)
    );

    // Select data levels on the active insertion line, video elsewhere
    always_comb begin
        ins_active_o = ins_line && work.en;
        if (ins_active_o)
            video_o = tx_bit ? LVL_HI : LVL_LO;
        else
            video_o = video_i;
    end

    AST_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ins_active_o |-> (video_o == LVL_HI || video_o == LVL_LO)); // R3
    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !work.en |-> !ins_active_o); // R7
endmodule

// File: tb/test_cgms_inserter.sv
module test_cgms_inserter;
    localparam int DATA_W = 10;
    localparam int INS    = 41;
    localparam int BCLK   = 4;
    localparam int OFS    = 8;
    localparam int LEN    = 140;
    localparam int NLINES = 43;
    localparam logic [DATA_W-1:0] LO = 10'd64;
    localparam logic [DATA_W-1:0] HI = 10'd700;

    typedef struct {
        logic [DATA_W-1:0] v;
        logic              a;
        string             tag;
    } exp_t;

    typedef struct {
        int         line;
        int         cyc;
        logic [1:0] a;
        logic [7:0] d;
    } wr_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic mode_2x = 1'b0;
    logic vsync = 1'b0;
    logic hsync = 1'b0;
    logic [DATA_W-1:0] video_i = '0;
    logic [DATA_W-1:0] video_o;
    logic ins_active;

    exp_t exp_q[$];
    wr_t  wq[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    cgms_inserter i_cgms_inserter (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .mode_2x_i    (mode_2x),
        .vsync_i      (vsync),
        .hsync_i      (hsync),
        .video_i      (video_i),
        .video_o      (video_o),
        .ins_active_o (ins_active)
    );

    // Monitor: pop one expected item per cycle and compare mid-cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (video_o !== e.v || ins_active !== e.a) begin
                n_fail++;
                $display("FAIL %s: video_o=%0d act=%0b expected video_o=%0d act=%0b",
                         e.tag, video_o, ins_active, e.v, e.a);
            end
        end
    end

    task automatic push_exp(input logic [DATA_W-1:0] v, input logic a, input string tag);
        exp_t e;
        e.v = v; e.a = a; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic sched_wr(input int line, input int cyc, input logic [1:0] a, input logic [7:0] d);
        wr_t w;
        w.line = line; w.cyc = cyc; w.a = a; w.d = d;
        wq.push_back(w);
    endtask

    // Driver: one frame of NLINES lines, expected samples from the requirements
    task automatic run_frame(input logic [13:0] word, input logic en, input logic m2, input string tag);
        int ofs_e = m2 ? 2 * OFS : OFS;
        int bc_e  = m2 ? 2 * BCLK : BCLK;
        mode_2x = m2;
        for (int ln = 1; ln <= NLINES; ln++) begin
            for (int c = 0; c < LEN; c++) begin
                @(posedge clk);
                #1;
                wr_en = 1'b0;
                if (wq.size() > 0 && wq[0].line == ln && wq[0].cyc == c) begin
                    wr_en   = 1'b1;
                    wr_addr = wq[0].a;
                    wr_data = wq[0].d;
                    void'(wq.pop_front());
                end
                vsync   = (c == LEN - 1) && (ln == NLINES);
                hsync   = (c == LEN - 1) && (ln != NLINES);
                video_i = DATA_W'((c * 7 + ln * 13) % 1024);
                if (ln == INS && en) begin
                    logic [DATA_W-1:0] v = LO;
                    if (c >= ofs_e && c < ofs_e + 14 * bc_e)
                        v = word[13 - (c - ofs_e) / bc_e] ? HI : LO;
                    push_exp(v, 1'b1, tag);
                end else if (ln == INS) begin
                    push_exp(video_i, 1'b0, tag);
                end else begin
                    push_exp(video_i, 1'b0, "R2 R9 non-insertion line passes video");
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: idle cycles after reset pass video through
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            #1;
            video_i = DATA_W'(100 + i * 31);
            push_exp(video_i, 1'b0, "R1 reset state");
        end
        @(posedge clk);
        #1;
        vsync = 1'b1;
        video_i = DATA_W'(5);
        push_exp(video_i, 1'b0, "R1 reset state");

        // Frame 1: nothing committed, insertion off
        run_frame(14'h0, 1'b0, 1'b0, "R1 R7 insertion off after reset");
        // Frame 2: full commit, single rate
        sched_wr(1, 2, 2'd0, 8'h2D);
        sched_wr(1, 3, 2'd1, 8'h96);
        sched_wr(1, 4, 2'd2, 8'h01);
        run_frame({6'h2D, 8'h96}, 1'b1, 1'b0, "R2 R3 R4 word on line 41");
        // Frame 3: field writes and address 3 only, double rate
        sched_wr(1, 2, 2'd0, 8'h0A);
        sched_wr(1, 3, 2'd1, 8'h3C);
        sched_wr(1, 4, 2'd3, 8'hFF);
        run_frame({6'h2D, 8'h96}, 1'b1, 1'b1, "R5 R6 R9 old word kept, doubled timing");
        // Frame 4: commit lands mid insertion line
        sched_wr(INS, 30, 2'd2, 8'h01);
        run_frame({6'h2D, 8'h96}, 1'b1, 1'b0, "R8 mid-line commit deferred");
        // Frame 5: deferred commit now visible
        run_frame({6'h0A, 8'h3C}, 1'b1, 1'b0, "R8 commit visible next frame");
        // Frame 6: disable
        sched_wr(1, 2, 2'd2, 8'h00);
        run_frame(14'h0, 1'b0, 1'b0, "R7 disabled line passes video");
        // Frame 7: new word in double rate
        sched_wr(1, 2, 2'd0, 8'h3F);
        sched_wr(1, 3, 2'd1, 8'h01);
        sched_wr(1, 4, 2'd2, 8'h01);
        run_frame({6'h3F, 8'h01}, 1'b1, 1'b1, "R3 R5 R7 recommit double rate");

        @(posedge clk);
        #1;
        vsync = 1'b0;
        hsync = 1'b0;
        wait (exp_q.size() == 0);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule